// File: doc/BRIEF.md
# Serial Receiver with Idle-Gap Message Framing

This block receives an asynchronous serial byte stream and stores the characters in a small receive FIFO. It samples the input line at sixteen times the bit rate and checks each start bit at its midpoint. Each character is ten bit periods long: one start bit, eight data bits sent least significant bit first, and one stop bit. A completed character is written into the FIFO. Software can service the FIFO on a programmable fill level, as with a conventional receive buffer.

The block also ends a message without looking at its content. A timer runs after every received character. When the line has stayed idle for a programmed number of character times, the block raises a sticky end-of-message flag. A message tail that is shorter than the fill level can then be drained straight away. The end-of-message flag, the fill-level flag, a framing error flag and an overflow flag are merged into one level-sensitive interrupt, and each cause has its own enable bit.

Top module: `serial_gap_rx`

## Requirements
- R1: The over-sample tick occurs every `baudDiv` clocks, and `baudDiv` values 0 and 1 both give one tick per clock. One bit lasts 16 ticks. Data bits are taken at mid-bit, least significant bit first, and bytes leave the FIFO in the order they arrived.
- R2: A falling edge whose line is back high when the start bit is sampled at mid-bit (the 8th tick after detection) is dropped as a glitch. No byte is stored, and the next real character is received normally.
- R3: `levelHit` is 1 exactly while `fifoLevel` is nonzero and `fifoCount` is at least `fifoLevel`.
- R4: A character that completes while the FIFO holds DEPTH (8) bytes is discarded. The count stays at DEPTH and `overflow` is set.
- R5: A stop bit sampled low sets `frameErr`. The byte is still stored.
- R6: `eomFlag` sets once the receiver has been idle for `gapChars` × 10 bit periods, measured from the stop-bit sample of the last character.
- R7: Every new character restarts the idle timer. A gap shorter than the programmed length never sets `eomFlag`.
- R8: `eomFlag` is armed only by a received character and disarms when it fires. After it is cleared, it stays 0 until a new character arrives, however long the line stays idle.
- R9: `irq` is the OR of the enabled causes. The enable bits are `intEn[0]` for the fill level, `intEn[1]` for framing error, `intEn[2]` for overflow and `intEn[3]` for end of message.
- R10: A `rdStrobe` pops one byte, and `rdData` shows that byte in the same cycle. A read of an empty FIFO returns 0 and leaves the count at 0.
- R11: Writing 1 to a `clrFlags` bit clears a sticky flag: bit 0 clears `frameErr`, bit 1 clears `overflow` and bit 2 clears `eomFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| baudDiv | input | DIV_W | Clocks per over-sample tick |
| fifoLevel | input | CNT_W | FIFO fill threshold (0 disables) |
| gapChars | input | GAP_W | Idle gap in character times |
| intEn | input | 4 | Per-cause interrupt enables |
| clrFlags | input | 3 | Write-1-to-clear for the sticky flags |
| rdStrobe | input | 1 | Pop one byte from the FIFO |
| rdData | output | 8 | Head byte of the FIFO, 0 when empty |
| fifoCount | output | CNT_W | Bytes stored |
| levelHit | output | 1 | Fill level reached |
| frameErr | output | 1 | Sticky framing error |
| overflow | output | 1 | Sticky overflow |
| eomFlag | output | 1 | Sticky end of message |
| irq | output | 1 | Combined level interrupt |

## Verification
A wrong bit count or a wrong sample point in the receive state machine shows up as corrupted bytes. The scoreboard catches these at the first FIFO drain after the faulty character. A wrong idle-timer target or a missed timer restart moves the moment `eomFlag` rises. The bench samples that flag two bit periods before the predicted edge and a little after it, so an error of a fraction of a character is caught within one message. A wrong full or empty decision shows within one character or one read: an extra byte, a changed count, or a missing overflow flag.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
  localparam int CHAR_BITS = 8;
  localparam int FRAME_BITS = 10;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
  } rxState_t;

  typedef struct packed {
    logic shiftIn;
    logic pushChar;
  } rxStrobe_t;
endpackage

// File: rtl/sgr_datapath.sv
module sgr_datapath import sgr_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strobe,
  input  logic                 rdStrobe,
  output logic                 rxSync,
  output logic [CHAR_BITS-1:0] rdData,
  output logic [CNT_W-1:0]     fifoCount,
  output logic                 fifoFull
);
  logic [1:0] syncReg;
  logic [CHAR_BITS-1:0] shiftReg;
  logic [CHAR_BITS-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop, fifoEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= 2'b11;
    else       syncReg <= {syncReg[0], rxLine};
  end
  assign rxSync = syncReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftIn) shiftReg <= {rxSync, shiftReg[CHAR_BITS-1:1]};
  end

  assign fifoFull  = (fifoCount == CNT_W'(DEPTH));
  assign fifoEmpty = (fifoCount == '0);
  assign doPush    = strobe.pushChar && !fifoFull;
  assign doPop     = rdStrobe && !fifoEmpty;
  assign rdData    = fifoEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end
endmodule

// File: rtl/sgr_control.sv
module sgr_control import sgr_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int GAP_W = 4,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxSync,
  input  logic             fifoFull,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [GAP_W-1:0] gapChars,
  input  logic [2:0]       clrFlags,
  output rxStrobe_t        strobe,
  output logic             rxIdle,
  output logic             frameErr,
  output logic             overflow,
  output logic             eomFlag
);
  localparam int OVS_W      = $clog2(OVS);
  localparam int MID        = OVS / 2 - 1;
  localparam int LAST       = OVS - 1;
  localparam int CHAR_TICKS = OVS * FRAME_BITS;
  localparam int IDLE_W     = GAP_W + $clog2(CHAR_TICKS + 1);
  localparam int BIT_W      = $clog2(CHAR_BITS);

  rxState_t state;
  logic [DIV_W-1:0] divCnt, divLimit;
  logic tick;
  logic [OVS_W-1:0] ovsCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [IDLE_W-1:0] idleCnt, gapTarget;
  logic armed;

  // over-sample tick generator
  assign divLimit = (baudDiv == '0) ? '0 : baudDiv - 1'b1;
  assign tick     = (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    strobe.shiftIn  = tick && (state == RX_DATA) && (ovsCnt == OVS_W'(LAST));
    strobe.pushChar = tick && (state == RX_STOP) && (ovsCnt == OVS_W'(LAST));
  end
  assign rxIdle = (state == RX_IDLE);

  // character framing state machine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      ovsCnt <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        RX_IDLE: if (tick && !rxSync) begin
          state  <= RX_START;
          ovsCnt <= '0;
        end
        RX_START: if (tick) begin
          if (ovsCnt == OVS_W'(MID)) begin
            ovsCnt <= '0;
            bitCnt <= '0;
            state  <= rxSync ? RX_IDLE : RX_DATA;
          end else ovsCnt <= ovsCnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (ovsCnt == OVS_W'(LAST)) begin
            ovsCnt <= '0;
            if (bitCnt == BIT_W'(CHAR_BITS - 1)) state <= RX_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end else ovsCnt <= ovsCnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (ovsCnt == OVS_W'(LAST)) begin
            ovsCnt <= '0;
            state  <= rxSync ? RX_IDLE : RX_WAITHI;
          end else ovsCnt <= ovsCnt + 1'b1;
        end
        RX_WAITHI: if (rxSync) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // sticky error flags, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameErr <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strobe.pushChar && !rxSync) frameErr <= 1'b1;
      else if (clrFlags[0])           frameErr <= 1'b0;
      if (strobe.pushChar && fifoFull) overflow <= 1'b1;
      else if (clrFlags[1])            overflow <= 1'b0;
    end
  end

  // idle-gap timer
  assign gapTarget = IDLE_W'(gapChars) * IDLE_W'(CHAR_TICKS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      armed   <= 1'b0;
      eomFlag <= 1'b0;
    end else begin
      if (strobe.pushChar) begin
        idleCnt <= '0;
        armed   <= 1'b1;
      end else if (state != RX_IDLE) begin
        idleCnt <= '0;
      end else if (armed && idleCnt >= gapTarget) begin
        armed   <= 1'b0;
        idleCnt <= '0;
      end else if (armed && tick) begin
        idleCnt <= idleCnt + 1'b1;
      end

      if (!strobe.pushChar && state == RX_IDLE && armed && idleCnt >= gapTarget)
        eomFlag <= 1'b1;
      else if (clrFlags[2])
        eomFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_gap_rx.sv
module serial_gap_rx import sgr_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int GAP_W = 4,
  parameter int OVS   = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic [DIV_W-1:0]     baudDiv,
  input  logic [CNT_W-1:0]     fifoLevel,
  input  logic [GAP_W-1:0]     gapChars,
  input  logic [3:0]           intEn,
  input  logic [2:0]           clrFlags,
  input  logic                 rdStrobe,
  output logic [CHAR_BITS-1:0] rdData,
  output logic [CNT_W-1:0]     fifoCount,
  output logic                 levelHit,
  output logic                 frameErr,
  output logic                 overflow,
  output logic                 eomFlag,
  output logic                 irq
);
  rxStrobe_t strobe;
  logic rxSync, fifoFull, rxIdle, chPush;

  sgr_control #(.DIV_W(DIV_W), .GAP_W(GAP_W), .OVS(OVS)) ctrl (
    .clk(clk), .rstN(rstN), .rxSync(rxSync), .fifoFull(fifoFull),
    .baudDiv(baudDiv), .gapChars(gapChars), .clrFlags(clrFlags),
    .strobe(strobe), .rxIdle(rxIdle), .frameErr(frameErr),
    .overflow(overflow), .eomFlag(eomFlag)
  );

  sgr_datapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobe(strobe),
    .rdStrobe(rdStrobe), .rxSync(rxSync), .rdData(rdData),
    .fifoCount(fifoCount), .fifoFull(fifoFull)
  );

  assign chPush   = strobe.pushChar;
  assign levelHit = (fifoLevel != '0) && (fifoCount >= fifoLevel);
  assign irq = |(intEn & {eomFlag, overflow, frameErr, levelHit});
endmodule

// File: rtl/sgr_checker.sv
module sgr_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fifoCount,
  input logic             rdStrobe,
  input logic             chPush,
  input logic             rxIdle,
  input logic             overflow,
  input logic             frameErr,
  input logic             eomFlag
);
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> ($past(fifoCount) == CNT_W'(DEPTH)));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fifoCount == '0 && !chPush) |=> (fifoCount == '0));

  // R5
  frame_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(chPush));

  // R6
  eom_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eomFlag) |-> ($past(rxIdle) && !$past(chPush)));
endmodule

bind serial_gap_rx sgr_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .rdStrobe(rdStrobe),
  .chPush(chPush), .rxIdle(rxIdle), .overflow(overflow),
  .frameErr(frameErr), .eomFlag(eomFlag)
);

// File: tb/serial_gap_rx_test.sv
module serial_gap_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int BIT_CLKS = DIV * 16;
  localparam int CHAR_CLKS = BIT_CLKS * 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic [15:0] baudDiv = 16'(DIV);
  logic [3:0] fifoLevel = 4'd4;
  logic [3:0] gapChars = 4'd2;
  logic [3:0] intEn = 4'hF;
  logic [2:0] clrFlags = 3'b000;
  logic rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic [3:0] fifoCount;
  logic levelHit, frameErr, overflow, eomFlag, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_gap_rx uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .fifoLevel(fifoLevel), .gapChars(gapChars), .intEn(intEn),
    .clrFlags(clrFlags), .rdStrobe(rdStrobe), .rdData(rdData),
    .fifoCount(fifoCount), .levelHit(levelHit), .frameErr(frameErr),
    .overflow(overflow), .eomFlag(eomFlag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: serialises one character and records the expected byte
  task automatic sendChar(input logic [7:0] b, input logic stopVal, input bit kept);
    rxLine = 1'b0;
    idle(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      idle(BIT_CLKS);
    end
    rxLine = stopVal;
    idle(BIT_CLKS);
    rxLine = 1'b1;
    if (kept) expQ.push_back(b);
  endtask

  // monitor: pops the FIFO and compares against the scoreboard queue
  task automatic drain(input string req);
    while (fifoCount != 0) begin
      logic [7:0] exp;
      rdStrobe = 1'b1;
      #1;
      exp = (expQ.size() > 0) ? expQ.pop_front() : 8'h00;
      check(rdData == exp, req, "byte order/value", rdData, exp);
      @(negedge clk);
      rdStrobe = 1'b0;
    end
    check(expQ.size() == 0, req, "bytes missing", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic clear(input logic [2:0] which);
    @(negedge clk);
    clrFlags = which;
    @(negedge clk);
    clrFlags = 3'b000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    check(fifoCount == 0, "reset", "count", fifoCount, 0);
    check(irq == 0, "reset R9", "irq", irq, 0);
    check(eomFlag == 0 && frameErr == 0 && overflow == 0, "reset", "flags", 0, 0);

    // short message below threshold, ended by idle gap
    sendChar(8'hA5, 1'b1, 1'b1);
    sendChar(8'h3C, 1'b1, 1'b1);
    sendChar(8'h01, 1'b1, 1'b1);
    check(fifoCount == 3, "R1", "count after 3", fifoCount, 3);
    check(levelHit == 0, "R3", "level below", levelHit, 0);
    idle(2 * CHAR_CLKS - 64);
    check(eomFlag == 0, "R6", "eom early", eomFlag, 0);
    idle(104);
    check(eomFlag == 1, "R6", "eom after gap", eomFlag, 1);
    check(irq == 1, "R9", "irq on eom", irq, 1);
    drain("R1");
    intEn = 4'b0111;
    @(negedge clk);
    check(irq == 0, "R9", "eom masked", irq, 0);
    intEn = 4'hF;
    @(negedge clk);
    check(irq == 1, "R9", "eom unmasked", irq, 1);
    clear(3'b100);
    check(eomFlag == 0, "R11", "eom cleared", eomFlag, 1'b0);
    idle(3 * CHAR_CLKS);
    check(eomFlag == 0, "R8", "no rearm without char", eomFlag, 0);

    // threshold reached
    sendChar(8'h11, 1'b1, 1'b1);
    sendChar(8'h22, 1'b1, 1'b1);
    sendChar(8'h33, 1'b1, 1'b1);
    check(levelHit == 0, "R3", "level at 3", levelHit, 0);
    sendChar(8'h44, 1'b1, 1'b1);
    check(levelHit == 1, "R3", "level at 4", levelHit, 1);
    check(irq == 1, "R9", "irq on level", irq, 1);
    drain("R10");
    check(levelHit == 0, "R3", "level after drain", levelHit, 0);
    idle(3 * CHAR_CLKS);
    clear(3'b100);

    // timer restart on each character
    sendChar(8'h81, 1'b1, 1'b1);
    idle(CHAR_CLKS * 3 / 2);
    check(eomFlag == 0, "R7", "short gap 1", eomFlag, 0);
    sendChar(8'h7E, 1'b1, 1'b1);
    idle(CHAR_CLKS * 3 / 2);
    check(eomFlag == 0, "R7", "short gap 2", eomFlag, 0);
    sendChar(8'hC3, 1'b1, 1'b1);
    idle(2 * CHAR_CLKS - 64);
    check(eomFlag == 0, "R7", "before final gap", eomFlag, 0);
    idle(104);
    check(eomFlag == 1, "R7", "after final gap", eomFlag, 1);
    drain("R1");
    clear(3'b100);

    // longer programmed gap
    gapChars = 4'd3;
    sendChar(8'h5F, 1'b1, 1'b1);
    idle(3 * CHAR_CLKS - 64);
    check(eomFlag == 0, "R6", "gap3 early", eomFlag, 0);
    idle(104);
    check(eomFlag == 1, "R6", "gap3 fired", eomFlag, 1);
    gapChars = 4'd2;
    drain("R6");
    clear(3'b100);

    // overflow
    for (int i = 0; i < 9; i++) sendChar(8'(i * 17 + 1), 1'b1, i < 8);
    check(fifoCount == 8, "R4", "count full", fifoCount, 8);
    check(overflow == 1, "R4", "overflow flag", overflow, 1);
    drain("R4");
    clear(3'b010);
    check(overflow == 0, "R11", "overflow cleared", overflow, 0);
    idle(3 * CHAR_CLKS);
    clear(3'b100);

    // framing error
    sendChar(8'h96, 1'b0, 1'b1);
    idle(BIT_CLKS);
    check(frameErr == 1, "R5", "frame flag", frameErr, 1);
    check(fifoCount == 1, "R5", "byte kept", fifoCount, 1);
    check(irq == 1, "R9", "irq on frame err", irq, 1);
    drain("R5");
    clear(3'b001);
    check(frameErr == 0, "R11", "frame cleared", frameErr, 0);
    idle(3 * CHAR_CLKS);
    clear(3'b100);

    // start glitch
    rxLine = 1'b0;
    idle(8);
    rxLine = 1'b1;
    idle(CHAR_CLKS + 80);
    check(fifoCount == 0, "R2", "glitch dropped", fifoCount, 0);
    check(eomFlag == 0, "R2", "glitch no eom", eomFlag, 0);
    sendChar(8'hE7, 1'b1, 1'b1);
    drain("R2");

    // empty read
    @(negedge clk);
    rdStrobe = 1'b1;
    #1;
    check(rdData == 0, "R10", "empty rdData", rdData, 0);
    @(negedge clk);
    rdStrobe = 1'b0;
    check(fifoCount == 0, "R10", "empty count", fifoCount, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule